// File: doc/BRIEF.md
# Per-Process Memory Node Occupancy Tracker with Context-Switch Prewake

This block keeps a count of mapped pages for every pairing of process slot and memory node. Each page map event adds one to a single counter. Each page unmap event takes one away. No scan of any table is ever needed. A node is active for a slot exactly while that slot's counter for the node is above zero. Any slot's active-node mask can be read combinationally at any time.

When the scheduler signals a context switch, it gives two slots: the process about to run and the one expected to run after it. The block ORs the two active masks together and, on the next cycle, presents:

- a wake mask, listing the nodes to bring from Nap up to Standby;
- a sleep mask, listing the nodes that may stay in Nap or return to it.

Both masks come with a one-cycle valid strobe, so a downstream power sequencer can start the transitions while the rest of the switch work is still in progress.

Top module: `pavm_active_tracker`

## Requirements
- R1: After reset, wake_mask and sleep_mask are 0, mask_valid and underflow_err are low, and rd_active reads 0 for every slot.
- R2: A map event (map_valid high) adds one to the counter selected by map_slot and map_node. That node's bit in the slot's active mask is 1 from the next cycle on.
- R3: An unmap event (unmap_valid high) takes one from the selected counter. The node stays active until its counter returns to zero, and becomes inactive in the cycle after the last unmap.
- R4: An unmap on a counter that is already zero leaves that counter at zero. From the next cycle, underflow_err is set and stays set until reset.
- R5: A map and an unmap in the same cycle on the same slot and node leave that counter unchanged and raise no error. On different counters, both apply.
- R6: Counters are 16 bits wide and saturate at 65535. A map on a full counter leaves it at 65535, and after saturation exactly 65535 unmaps return it to zero.
- R7: When sw_valid is high in a cycle, mask_valid is high for exactly the next cycle. In that cycle, wake_mask equals the OR of the active masks of sw_next_slot and sw_after_slot, as they stood in the switch cycle (before same-cycle map or unmap events).
- R8: Whenever mask_valid is high, sleep_mask equals the bitwise complement of wake_mask (bit n is node n).
- R9: Between switch events, wake_mask and sleep_mask hold their last values, and mask_valid is low.
- R10: When sw_next_slot equals sw_after_slot, wake_mask is that one slot's active mask.
- R11: rd_active shows the active mask of rd_slot combinationally. It changes only after map or unmap events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| map_valid | input | 1 | Page map event |
| map_slot | input | 3 | Process slot of the map event |
| map_node | input | 4 | Memory node of the map event |
| unmap_valid | input | 1 | Page unmap event |
| unmap_slot | input | 3 | Process slot of the unmap event |
| unmap_node | input | 4 | Memory node of the unmap event |
| sw_valid | input | 1 | Context switch signalled |
| sw_next_slot | input | 3 | Slot about to run |
| sw_after_slot | input | 3 | Slot likely to run after it |
| wake_mask | output | 16 | Nodes to raise from Nap to Standby |
| sleep_mask | output | 16 | Nodes that may stay in or return to Nap |
| mask_valid | output | 1 | One-cycle strobe for the masks |
| rd_slot | input | 3 | Slot whose active mask is read |
| rd_active | output | 16 | Active-node mask of rd_slot |
| underflow_err | output | 1 | Sticky flag for an unmap on an empty counter |

## Verification
The hardest state to reach from the ports is a saturated counter. Getting there takes 65535 maps on one counter, so a directed phase issues 65537 of them. It then unmaps 65534 times and checks that the node is still active, and checks that the final unmap clears it.

Random traffic is drawn over few slots and nodes with frequent unmaps. This reaches the other corners often:
- unmaps on empty counters;
- map and unmap colliding on the same counter;
- switches whose two slots coincide.

// File: rtl/pavm_pkg.sv
package pavm_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_DEC   = 2'd2,
    OP_UNDER = 2'd3
  } cnt_op_e;

  // Decide what one counter does this cycle.
  function automatic cnt_op_e decode_op(input logic inc, input logic dec,
                                        input logic is_zero);
    if (inc && dec)      return OP_HOLD;
    else if (inc)        return OP_INC;
    else if (dec)        return is_zero ? OP_UNDER : OP_DEC;
    else                 return OP_HOLD;
  endfunction
endpackage

// File: rtl/pavm_cnt_cell.sv
module pavm_cnt_cell
  import pavm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic active,
  output logic underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  cnt_op_e          op;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input cnt_op_e o);
    case (o)
      OP_INC:  return (c == CNT_MAX) ? c : c + 1'b1;
      OP_DEC:  return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign op        = decode_op(inc, dec, cnt_q == '0);
  assign underflow = (op == OP_UNDER);
  assign active    = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_count(cnt_q, op);
  end
endmodule

// File: rtl/pavm_wake_unit.sv
module pavm_wake_unit #(
  parameter int NODES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_valid,
  input  logic [NODES-1:0] act_next,
  input  logic [NODES-1:0] act_after,
  output logic [NODES-1:0] wake_mask,
  output logic [NODES-1:0] sleep_mask,
  output logic             mask_valid
);
  function automatic logic [NODES-1:0] union_mask(input logic [NODES-1:0] a,
                                                  input logic [NODES-1:0] b);
    return a | b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_mask  <= '0;
      sleep_mask <= '0;
      mask_valid <= 1'b0;
    end else begin
      mask_valid <= sw_valid;
      if (sw_valid) begin
        wake_mask  <= union_mask(act_next, act_after);
        sleep_mask <= ~union_mask(act_next, act_after);
      end
    end
  end
endmodule

// File: rtl/pavm_active_tracker.sv
module pavm_active_tracker #(
  parameter int SLOTS  = 8,
  parameter int NODES  = 16,
  parameter int CNT_W  = 16,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int NODE_W = $clog2(NODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_valid,
  input  logic [SLOT_W-1:0] map_slot,
  input  logic [NODE_W-1:0] map_node,
  input  logic              unmap_valid,
  input  logic [SLOT_W-1:0] unmap_slot,
  input  logic [NODE_W-1:0] unmap_node,
  input  logic              sw_valid,
  input  logic [SLOT_W-1:0] sw_next_slot,
  input  logic [SLOT_W-1:0] sw_after_slot,
  output logic [NODES-1:0]  wake_mask,
  output logic [NODES-1:0]  sleep_mask,
  output logic              mask_valid,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [NODES-1:0]  rd_active,
  output logic              underflow_err
);
  logic [SLOTS-1:0][NODES-1:0] act_tbl;
  logic [SLOTS-1:0][NODES-1:0] under_tbl;
  logic                        underflow_any;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    for (genvar n = 0; n < NODES; n++) begin : g_node
      logic hit_inc, hit_dec;
      assign hit_inc = map_valid   && (map_slot   == SLOT_W'(s)) && (map_node   == NODE_W'(n));
      assign hit_dec = unmap_valid && (unmap_slot == SLOT_W'(s)) && (unmap_node == NODE_W'(n));
      pavm_cnt_cell #(.CNT_W(CNT_W)) u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (hit_inc),
        .dec       (hit_dec),
        .active    (act_tbl[s][n]),
        .underflow (under_tbl[s][n])
      );
    end
  end

  assign underflow_any = |under_tbl;
  assign rd_active     = act_tbl[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             underflow_err <= 1'b0;
    else if (underflow_any) underflow_err <= 1'b1;
  end

  pavm_wake_unit #(.NODES(NODES)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_valid   (sw_valid),
    .act_next   (act_tbl[sw_next_slot]),
    .act_after  (act_tbl[sw_after_slot]),
    .wake_mask  (wake_mask),
    .sleep_mask (sleep_mask),
    .mask_valid (mask_valid)
  );
endmodule

// File: rtl/pavm_tracker_chk.sv
module pavm_tracker_chk #(
  parameter int NODES  = 16,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_valid,
  input logic              map_valid,
  input logic              unmap_valid,
  input logic              mask_valid,
  input logic [NODES-1:0]  wake_mask,
  input logic [NODES-1:0]  sleep_mask,
  input logic              underflow_err,
  input logic              underflow_any,
  input logic [SLOT_W-1:0] rd_slot,
  input logic [NODES-1:0]  rd_active
);
  // R8
  sleep_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> (sleep_mask == ~wake_mask));
  // R7
  strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_valid |=> mask_valid);
  // R9
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_valid |=> !mask_valid);
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_valid |-> ($stable(wake_mask) && $stable(sleep_mask)));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);
  // R4
  err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_any |=> underflow_err);
  // R11
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_valid && !unmap_valid) |=> (!$stable(rd_slot) || $stable(rd_active)));
endmodule

bind pavm_active_tracker pavm_tracker_chk #(.NODES(NODES), .SLOT_W(SLOT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_valid      (sw_valid),
  .map_valid     (map_valid),
  .unmap_valid   (unmap_valid),
  .mask_valid    (mask_valid),
  .wake_mask     (wake_mask),
  .sleep_mask    (sleep_mask),
  .underflow_err (underflow_err),
  .underflow_any (underflow_any),
  .rd_slot       (rd_slot),
  .rd_active     (rd_active)
);

// File: tb/pavm_active_tracker_test.sv
`timescale 1ns/1ps
module pavm_active_tracker_test;
  localparam int MAXC = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_valid = 0, unmap_valid = 0, sw_valid = 0;
  logic [2:0] map_slot = 0, unmap_slot = 0, sw_next_slot = 0, sw_after_slot = 0, rd_slot = 0;
  logic [3:0] map_node = 0, unmap_node = 0;
  logic [15:0] wake_mask, sleep_mask, rd_active;
  logic mask_valid, underflow_err;

  int cnt [8][16];
  logic [15:0] exp_wake = '0;
  logic exp_err = 0;
  int n_chk = 0, n_bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pavm_active_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .map_valid(map_valid), .map_slot(map_slot), .map_node(map_node),
    .unmap_valid(unmap_valid), .unmap_slot(unmap_slot), .unmap_node(unmap_node),
    .sw_valid(sw_valid), .sw_next_slot(sw_next_slot), .sw_after_slot(sw_after_slot),
    .wake_mask(wake_mask), .sleep_mask(sleep_mask), .mask_valid(mask_valid),
    .rd_slot(rd_slot), .rd_active(rd_active), .underflow_err(underflow_err)
  );

  function automatic logic [15:0] model_act(input int s);
    logic [15:0] m = '0;
    for (int n = 0; n < 16; n++) m[n] = (cnt[s][n] != 0);
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_read(input string req, input int s);
    rd_slot = 3'(s);
    #0.5;
    check(req, {16'h0, rd_active}, {16'h0, model_act(s)});
  endtask

  // One clock: drive after negedge, update model, sample at next negedge.
  task automatic step(input bit mv, input int ms, input int mn,
                      input bit uv, input int us, input int un,
                      input bit sv, input int sn, input int sa, input bit chk);
    bit same;
    logic exp_valid;
    map_valid = mv; map_slot = 3'(ms); map_node = 4'(mn);
    unmap_valid = uv; unmap_slot = 3'(us); unmap_node = 4'(un);
    sw_valid = sv; sw_next_slot = 3'(sn); sw_after_slot = 3'(sa);
    exp_valid = sv;
    if (sv) exp_wake = model_act(sn) | model_act(sa);
    same = mv && uv && (ms == us) && (mn == un);
    if (!same) begin
      if (mv && cnt[ms][mn] < MAXC) cnt[ms][mn]++;
      if (uv) begin
        if (cnt[us][un] == 0) exp_err = 1;
        else cnt[us][un]--;
      end
    end
    @(negedge clk);
    map_valid = 0; unmap_valid = 0; sw_valid = 0;
    if (chk) begin
      check("R7 strobe", {31'h0, mask_valid}, {31'h0, exp_valid});
      check(sv ? "R7 wake" : "R9 hold", {16'h0, wake_mask}, {16'h0, exp_wake});
      if (sv) check("R8 sleep", {16'h0, sleep_mask}, {16'h0, ~exp_wake});
      check("R4 err", {31'h0, underflow_err}, {31'h0, exp_err});
    end
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 195000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<195000", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd7321));
    for (int s = 0; s < 8; s++) for (int n = 0; n < 16; n++) cnt[s][n] = 0;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 wake", {16'h0, wake_mask}, 32'h0);
    check("R1 sleep", {16'h0, sleep_mask}, 32'h0);
    check("R1 valid", {31'h0, mask_valid}, 32'h0);
    check("R1 err", {31'h0, underflow_err}, 32'h0);
    for (int s = 0; s < 8; s++) check_read("R1 read", s);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 map makes node active
    step(1, 2, 5, 0, 0, 0, 0, 0, 0, 1);
    check_read("R2 map", 2);
    step(1, 2, 5, 0, 0, 0, 0, 0, 0, 1);
    // R3 node remains active until last unmap
    step(0, 0, 0, 1, 2, 5, 0, 0, 0, 1);
    check_read("R3 still active", 2);
    step(0, 0, 0, 1, 2, 5, 0, 0, 0, 1);
    check_read("R3 cleared", 2);
    // R5 collision on same counter cancels, no error
    step(1, 3, 1, 1, 3, 1, 0, 0, 0, 1);
    check_read("R5 same cancel", 3);
    // R5 different counters both apply
    step(1, 3, 2, 0, 0, 0, 0, 0, 0, 1);
    step(1, 3, 4, 1, 3, 2, 0, 0, 0, 1);
    check_read("R5 diff both", 3);
    // R7 switch with map in same cycle (uses pre-update table)
    step(1, 1, 9, 0, 0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0, 1, 1, 3, 1);
    // R9 hold across idle cycles
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R10 same slot for next and after
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 1);
    // R4 underflow sets sticky error
    step(0, 0, 0, 1, 6, 6, 0, 0, 0, 1);
    check_read("R4 stays zero", 6);
    step(1, 6, 6, 0, 0, 0, 0, 0, 0, 1);
    check("R4 sticky", {31'h0, underflow_err}, 32'h1);

    // R6 saturation
    for (int i = 0; i < MAXC + 2; i++) step(1, 7, 15, 0, 0, 0, 0, 0, 0, 0);
    check_read("R6 saturated active", 7);
    for (int i = 0; i < MAXC - 1; i++) step(0, 0, 0, 1, 7, 15, 0, 0, 0, 0);
    check_read("R6 one left", 7);
    step(0, 0, 0, 1, 7, 15, 0, 0, 0, 1);
    check_read("R6 drained", 7);

    // Random traffic over R2 R3 R5 R7 R8 R10 R11
    for (int i = 0; i < 4000; i++) begin
      bit mv, uv, sv;
      mv = ($urandom % 3) == 0;
      uv = ($urandom % 3) == 0;
      sv = ($urandom % 5) == 0;
      step(mv, $urandom % 3, $urandom % 4, uv, $urandom % 3, $urandom % 4,
           sv, $urandom % 4, $urandom % 4, 1);
      if ((i % 8) == 0) check_read("R11 read", $urandom % 8);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule